// File: doc/BRIEF.md
# Tick-Driven Interval Timer

This block is a register-mapped countdown timer that advances only when an external one-microsecond tick strobe is high. Software programs it through two 32-bit words: a trigger word that carries the run flag, the repeat flag and a 29-bit start count, and a status word that shows the live count and the pending interrupt. Writing the status word with bit 30 set acknowledges the interrupt.

A loaded count of N expires on the (N+1)-th tick. In single-shot mode the timer halts after expiry. In repeating mode it reloads the stored start count and keeps running. Each expiry sets a sticky, level-high interrupt that stays high until software clears it. When an expiry and a clear land in the same cycle, the expiry wins. A write of zero to the trigger word halts the timer at once.

Top module: `tick_interval_timer`

## Requirements
- R1: The trigger word sits at byte offset 0x0. Bit 31 is the run flag, bit 30 is the repeat flag, and bits 28:0 are the start count (maximum 0x1FFFFFFF); bit 29 is ignored. A write with bit 31 set loads the count and starts the timer.
- R2: A trigger write with bit 31 clear, including a write of zero, stops the timer. The live count then takes the written count and stays frozen while ticks arrive.
- R3: In single-shot mode (bit 31 = 1, bit 30 = 0) the timer expires once, halts with the count at zero, and does not fire again on later ticks.
- R4: In repeating mode (bits 31 and 30 both set) each expiry reloads the start count and the timer keeps running, so it fires again every N+1 ticks.
- R5: A loaded count N decrements by one per tick and expires on tick N+1. N = 0 expires on the first tick.
- R6: A write to offset 0x4 with bit 30 set clears the pending interrupt. A write to offset 0x4 with bit 30 clear has no effect.
- R7: The output `irq` is high exactly while an interrupt is pending, and it stays high until it is cleared.
- R8: The count changes only in cycles where `tick_en` is high.
- R9: A read of offset 0x4 returns the live count in bits 28:0 and the pending flag in bit 30, with every other bit zero.
- R10: A trigger write while the timer runs restarts the countdown from the new value. A write in the same cycle as a tick takes precedence over the tick.
- R11: If an expiry and a clear write fall in the same cycle, the interrupt stays pending.
- R12: A read of offset 0x0 returns the run state in bit 31, the repeat flag in bit 30 and the stored start count in bits 28:0. Reads of other offsets return zero. Reset clears every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | One-cycle tick strobe that advances the count |
| irq | output | 1 | Level-high interrupt, pending until cleared |

## Verification
The bench builds the block with its default 4-bit byte address and the full 29-bit count field. This lets it load the largest start count and confirm that bit 29 is dropped. It also lets it probe the two unused offsets and the status word's bit positions exactly as software sees them. With single-tick bursts the bench reaches the N = 0 expiry, a restart in the middle of a countdown, and the cycle where an expiry and a clear write coincide.

// File: rtl/ivt_pkg.sv
// Package: shared constants and types for the tick interval timer.
// Assumes a 32-bit register word and fixed field positions that software decodes.
package ivt_pkg;
    parameter int DATA_W   = 32;
    parameter int CNT_W    = 29;
    parameter int RUN_BIT  = 31;
    parameter int REP_BIT  = 30;
    parameter int CLR_BIT  = 30;
    parameter int PEND_BIT = 30;
    parameter int TRIG_OFS = 0;
    parameter int STAT_OFS = 4;

    typedef struct packed {
        logic             run;
        logic             rep;
        logic [CNT_W-1:0] count;
    } trig_cfg_t;
endpackage

// File: rtl/ivt_regs.sv
// Module: register decode for the interval timer.
// Turns bus writes into load and clear strobes, keeps the repeat flag and the
// start count, and builds the combinational read word. Assumes single-cycle writes.
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              load_stb,
    output trig_cfg_t         load_cfg,
    output logic              clr_stb,
    output logic              rep_q,
    output logic [CNT_W-1:0]  start_q,
    input  logic              run_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              pend_q
);
    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    // Decode: write strobes per register and the fields of a trigger write.
    always_comb begin
        load_stb       = bus_we && (bus_addr == TRIG_A);
        clr_stb        = bus_we && (bus_addr == STAT_A) && bus_wdata[CLR_BIT];
        load_cfg.run   = bus_wdata[RUN_BIT];
        load_cfg.rep   = bus_wdata[REP_BIT];
        load_cfg.count = bus_wdata[CNT_W-1:0];
    end

    // Storage: keep the repeat flag and start count for reload and read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q   <= 1'b0;
            start_q <= '0;
        end else if (load_stb) begin
            rep_q   <= load_cfg.rep;
            start_q <= load_cfg.count;
        end
    end

    // Read mux: assemble the addressed word from its fields.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == TRIG_A) begin
            bus_rdata[RUN_BIT]    = run_q;
            bus_rdata[REP_BIT]    = rep_q;
            bus_rdata[CNT_W-1:0]  = start_q;
        end else if (bus_addr == STAT_A) begin
            bus_rdata[PEND_BIT]   = pend_q;
            bus_rdata[CNT_W-1:0]  = cnt_q;
        end
    end
endmodule

// File: rtl/ivt_counter.sv
// Module: countdown core. It loads on a trigger write, decrements once per tick,
// and on the tick at zero either reloads (repeat) or halts (single-shot).
// Assumes a load takes precedence over a tick in the same cycle.
module ivt_counter
    import ivt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_stb,
    input  trig_cfg_t        load_cfg,
    input  logic             rep_q,
    input  logic [CNT_W-1:0] start_q,
    output logic             run_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    logic at_zero;

    // Expiry detect: a running count sees a tick while at zero, with no load.
    always_comb begin
        at_zero = (cnt_q == '0);
        expire  = run_q && tick_en && at_zero && !load_stb;
    end

    // Count state: load, decrement, reload or halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load_stb) begin
            run_q <= load_cfg.run;
            cnt_q <= load_cfg.count;
        end else if (run_q && tick_en) begin
            if (at_zero) begin
                if (rep_q) cnt_q <= start_q;
                else       run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ivt_irq.sv
// Module: sticky interrupt flag. Expiry sets it, a clear strobe drops it,
// and an expiry in the same cycle as a clear keeps it set.
module ivt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_stb,
    output logic pend_q
);
    // Pending flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (expire)  pend_q <= 1'b1;
        else if (clr_stb) pend_q <= 1'b0;
    end
endmodule

// File: rtl/tick_interval_timer.sv
// Module: top of the tick-driven interval timer. It joins the register decode,
// the countdown core and the interrupt flag. Assumes tick_en is a one-cycle
// strobe produced by an external prescaler.
module tick_interval_timer
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_en,
    output logic              irq
);
    logic             load_stb;
    trig_cfg_t        load_cfg;
    logic             clr_stb;
    logic             rep_q;
    logic [CNT_W-1:0] start_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             expire;

    ivt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_stb(load_stb),
        .load_cfg(load_cfg), .clr_stb(clr_stb), .rep_q(rep_q), .start_q(start_q),
        .run_q(run_q), .cnt_q(cnt_q), .pend_q(pend_q)
    );

    ivt_counter u_counter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_stb(load_stb),
        .load_cfg(load_cfg), .rep_q(rep_q), .start_q(start_q),
        .run_q(run_q), .cnt_q(cnt_q), .expire(expire)
    );

    ivt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr_stb(clr_stb), .pend_q(pend_q)
    );

    // Output: the interrupt line follows the pending flag.
    assign irq = pend_q;
endmodule

// File: rtl/ivt_checker.sv
// Module: temporal properties of the interval timer, bound to the top module.
module ivt_checker
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              tick_en,
    input logic              irq,
    input logic              run_q,
    input logic              rep_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  start_q
);
    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    a_r2_zero_write_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == TRIG_A && bus_wdata == 32'd0) |=> (!run_q && cnt_q == '0));

    a_r3_single_shot_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !rep_q && tick_en && cnt_q == '0 && !bus_we) |=> (!run_q && irq));

    a_r4_repeat_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && rep_q && tick_en && cnt_q == '0 && !bus_we) |=> (run_q && irq && cnt_q == start_q));

    a_r5_one_step_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_en && cnt_q != '0 && !bus_we) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_we && bus_addr == STAT_A && bus_wdata[CLR_BIT])) |=> irq);

    a_r8_still_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !bus_we) |=> ($stable(cnt_q) && $stable(run_q)));

    a_r11_expiry_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && tick_en && cnt_q == '0 && bus_we && bus_addr == STAT_A) |=> irq);
endmodule

bind tick_interval_timer ivt_checker #(.ADDR_W(ADDR_W)) u_ivt_checker (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .tick_en(tick_en), .irq(irq), .run_q(run_q),
    .rep_q(rep_q), .cnt_q(cnt_q), .start_q(start_q)
);

// File: tb/tick_interval_timer_bench.sv
// Bench: a driver pushes expected reads into a queue and a monitor on the
// falling edge pops and compares the read word and the interrupt line.
module tick_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [3:0]  addr;
        logic [31:0] data;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    tick_interval_timer u_tick_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Monitor: compare one expected item per falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (bus_rdata !== it.data || irq !== it.irq) begin
                errors++;
                $display("FAIL %s addr=%0h rdata=%08h irq=%0b expected rdata=%08h irq=%0b",
                         it.tag, it.addr, bus_rdata, irq, it.data, it.irq);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] d,
                             input logic i, input string tag);
        exp_t it;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = a;
        it.addr = a; it.data = d; it.irq = i; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        expect_rd(4'h0, 32'h0, 1'b0, "R12 reset trigger word");
        expect_rd(4'h4, 32'h0, 1'b0, "R9 reset status word");

        // Single shot, N=5
        wr(4'h0, 32'h8000_0005);
        expect_rd(4'h0, 32'h8000_0005, 1'b0, "R1 trigger read-back");
        expect_rd(4'h4, 32'h0000_0005, 1'b0, "R1 count loaded");
        ticks(5);
        expect_rd(4'h4, 32'h0000_0000, 1'b0, "R5 no expiry after N ticks");
        ticks(1);
        expect_rd(4'h4, 32'h4000_0000, 1'b1, "R5 expiry on tick N+1");
        expect_rd(4'h0, 32'h0000_0005, 1'b1, "R3 halted after single shot");
        ticks(3);
        expect_rd(4'h4, 32'h4000_0000, 1'b1, "R7 irq held while pending");
        expect_rd(4'h8, 32'h0, 1'b1, "R12 unused offset reads zero");

        // Clear behaviour
        wr(4'h4, 32'h0000_0001);
        expect_rd(4'h4, 32'h4000_0000, 1'b1, "R6 write without bit 30 ignored");
        wr(4'h4, 32'h4000_0000);
        expect_rd(4'h4, 32'h0000_0000, 1'b0, "R6 clear drops pending");
        ticks(4);
        expect_rd(4'h4, 32'h0000_0000, 1'b0, "R3 no second firing");

        // Repeating, N=2
        wr(4'h0, 32'hC000_0002);
        ticks(3);
        expect_rd(4'h4, 32'h4000_0002, 1'b1, "R4 first firing reloads");
        wr(4'h4, 32'h4000_0000);
        ticks(2);
        expect_rd(4'h4, 32'h0000_0000, 1'b0, "R4 counting toward second firing");
        ticks(1);
        expect_rd(4'h4, 32'h4000_0002, 1'b1, "R4 second firing");
        expect_rd(4'h0, 32'hC000_0002, 1'b1, "R12 repeat mode read-back");
        wr(4'h4, 32'h4000_0000);
        ticks(1);
        wr(4'h0, 32'h0000_0000);
        expect_rd(4'h0, 32'h0000_0000, 1'b0, "R2 zero write stops");
        ticks(5);
        expect_rd(4'h4, 32'h0000_0000, 1'b0, "R2 no firing after stop");

        // Run flag clear with a count
        wr(4'h0, 32'h0000_0007);
        ticks(10);
        expect_rd(4'h4, 32'h0000_0007, 1'b0, "R2 count frozen when stopped");

        // Ticks gate the count
        wr(4'h0, 32'h8000_0003);
        repeat (10) @(posedge clk);
        expect_rd(4'h4, 32'h0000_0003, 1'b0, "R8 no change without tick");
        ticks(2);
        expect_rd(4'h4, 32'h0000_0001, 1'b0, "R8 two ticks two steps");

        // Restart while running
        wr(4'h0, 32'h8000_0004);
        expect_rd(4'h4, 32'h0000_0004, 1'b0, "R10 restart loads new count");
        ticks(4);
        expect_rd(4'h4, 32'h0000_0000, 1'b0, "R10 restart no early expiry");
        ticks(1);
        expect_rd(4'h4, 32'h4000_0000, 1'b1, "R10 restart expiry");
        wr(4'h4, 32'h4000_0000);

        // Write in the same cycle as a tick wins
        wr(4'h0, 32'h8000_0003);
        @(posedge clk); #1;
        tick_en = 1'b1; bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h8000_0006;
        @(posedge clk); #1;
        tick_en = 1'b0; bus_we = 1'b0;
        expect_rd(4'h4, 32'h0000_0006, 1'b0, "R10 load beats tick");

        // N=0 and expiry against a clear
        wr(4'h0, 32'h8000_0000);
        @(posedge clk); #1;
        tick_en = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h4000_0000;
        @(posedge clk); #1;
        tick_en = 1'b0; bus_we = 1'b0;
        expect_rd(4'h4, 32'h4000_0000, 1'b1, "R11 expiry beats clear, R5 N=0");
        wr(4'h4, 32'h4000_0000);
        expect_rd(4'h4, 32'h0000_0000, 1'b0, "R6 later clear works");

        // Largest count, bit 29 dropped
        wr(4'h0, 32'hBFFF_FFFF);
        expect_rd(4'h0, 32'h9FFF_FFFF, 1'b0, "R1 max count, bit 29 ignored");
        expect_rd(4'h4, 32'h1FFF_FFFF, 1'b0, "R1 max count loaded");
        ticks(2);
        expect_rd(4'h4, 32'h1FFF_FFFD, 1'b0, "R5 max count steps");
        wr(4'h0, 32'h0000_0000);

        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule